// File: doc/BRIEF.md
# ACPI SCI event aggregator

This block gathers power-management events into a single level-sensitive system-control interrupt (SCI). It holds two register groups. The first is a general-purpose event window: a status half and an enable half, each `GPE_BYTES` bytes wide. The second is a fixed-event pair with a 16-bit status and a 16-bit enable. Event strobes set status bits, and software clears them by writing ones. SCI is high while any enabled event of the kinds that may interrupt is pending. Only certain fixed-event bits and two bits of the first general-purpose byte can drive it.

The block also has a power-management command port. Writing the command 0xF1 turns on an ACPI-enable flag in a read-only control byte, and writing 0xF0 turns it off. When a configuration byte allows it, every command write also produces a one-cycle system-management interrupt (SMI) pulse. A timer-wakeup arm output tells a timer (outside the block) when an overflow should be scheduled.

Software reaches all of this through a byte-wide register bus. A write is one cycle with `bus_wr` high. A read is combinational from `bus_addr`. With the default `GPE_BYTES`=2 the map is as follows:
- 0–1: GPE status, little-endian.
- 2–3: GPE enable.
- 4–5: fixed status.
- 6–7: fixed enable.
- 8: control.
- 9: command.
- 10: configuration.
- Any other address reads 0.

Top module: `pm_event_hub`

## Requirements
- R1: After reset every status, enable, control, command and configuration byte reads 0, and `sci`, `smi` are low.
- R2: GPE window: address k (k < GPE_BYTES) holds status bits 8k+7..8k and address GPE_BYTES+k holds enable bits 8k+7..8k (little-endian); enable bytes are plain read/write.
- R3: Status bits (GPE and fixed) are set by a high event strobe at a clock edge and cleared by writing 1 to them; writing 0 leaves them unchanged, and a strobe in the same cycle as a clear leaves the bit set.
- R4: Fixed status/enable sit at addresses 4–5 and 6–7 (low byte first); only status bits 0 (timer), 5 (global lock), 8 (power button) and 10 (RTC) exist, and SCI is high when any of them is set together with its enable bit.
- R5: SCI is also high when GPE status bit 1 or bit 2 is set with its enable bit; no other GPE bit affects SCI.
- R6: SCI is re-evaluated from register state at once: it follows a write or event in the cycle right after the clock edge that stored it.
- R7: Writing 0xF1 to the command port (address 9) sets the ACPI-enable flag (bit 0 of control address 8), 0xF0 clears it, other values leave it; the control byte ignores direct writes; address 9 reads back the last command.
- R8: `smi` is a one-cycle pulse in the cycle after a command write, produced only if bit 1 of the configuration byte (address 10) is set.
- R9: `tmr_wake` is high exactly while fixed enable bit 0 is set and fixed status bit 0 is clear.
- R10: A high `evt_pwr_btn` strobe sets fixed status bit 8; `evt_timer`, `evt_gbl_lock`, `evt_rtc` set bits 0, 5 and 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for one byte |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| gpe_evt | input | 8*GPE_BYTES | General-purpose event strobes, one per status bit |
| evt_timer | input | 1 | Timer overflow event |
| evt_gbl_lock | input | 1 | Global lock release event |
| evt_pwr_btn | input | 1 | Power-button request |
| evt_rtc | input | 1 | Real-time-clock alarm event |
| sci | output | 1 | Level system-control interrupt |
| smi | output | 1 | One-cycle system-management interrupt pulse |
| tmr_wake | output | 1 | Arm request for timer overflow wakeup |

## Verification
The bench builds the block with the defaults, GPE_BYTES=2 and ADDR_W=4. This places both GPE status bytes and both enable bytes in the 11-byte map. Events on high-byte GPE bits, and on low-byte bits other than 1 and 2, can then be shown not to reach SCI. The bench also exercises the fixed events in both bytes, the command codes and the gated SMI pulse. At every clock a behavioural model is compared with `sci`, `smi` and `tmr_wake`, and the register reads are compared with the same model.

// File: rtl/pm_event_pkg.sv
package pm_event_pkg;

    localparam int PM1_TMR_BIT = 0;
    localparam int PM1_GBL_BIT = 5;
    localparam int PM1_PWR_BIT = 8;
    localparam int PM1_RTC_BIT = 10;

    localparam logic [15:0] PM1_IMPL_MASK =
        (16'd1 << PM1_TMR_BIT) | (16'd1 << PM1_GBL_BIT) |
        (16'd1 << PM1_PWR_BIT) | (16'd1 << PM1_RTC_BIT);

    localparam logic [7:0] GPE_SCI_MASK = 8'h06;

    localparam logic [7:0] CMD_ACPI_ON  = 8'hF1;
    localparam logic [7:0] CMD_ACPI_OFF = 8'hF0;
    localparam int         CFG_SMI_BIT  = 1;

    typedef struct packed {
        logic rtc;
        logic pwr_btn;
        logic gbl_lock;
        logic timer;
    } fixed_evt_t;

    function automatic logic [15:0] fixed_set_vec(fixed_evt_t e);
        logic [15:0] v;
        v = '0;
        v[PM1_TMR_BIT] = e.timer;
        v[PM1_GBL_BIT] = e.gbl_lock;
        v[PM1_PWR_BIT] = e.pwr_btn;
        v[PM1_RTC_BIT] = e.rtc;
        return v;
    endfunction

    function automatic logic [7:0] w1c_byte(logic [7:0] cur, logic [7:0] clr,
                                            logic [7:0] set);
        return (cur & ~clr) | set;
    endfunction

endpackage

// File: rtl/gpe_bank.sv
module gpe_bank
    import pm_event_pkg::*;
#(
    parameter int BYTES = 2,
    localparam int LA_W = (2 * BYTES > 1) ? $clog2(2 * BYTES) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr,
    input  logic [LA_W-1:0]    addr,
    input  logic [7:0]         wdata,
    input  logic [BYTES*8-1:0] evt,
    output logic [7:0]         rd_byte,
    output logic [7:0]         sts0,
    output logic [7:0]         en0
);

    logic [BYTES*8-1:0] sts_flat;
    logic [BYTES*8-1:0] en_flat;

    for (genvar b = 0; b < BYTES; b++) begin : g_byte
        logic [7:0] sts_q;
        logic [7:0] en_q;
        logic       hit_sts;
        logic       hit_en;

        assign hit_sts = wr && (int'(addr) == b);
        assign hit_en  = wr && (int'(addr) == BYTES + b);

        always_ff @(posedge clk) begin
            if (rst) begin
                sts_q <= '0;
                en_q  <= '0;
            end else begin
                sts_q <= w1c_byte(sts_q, hit_sts ? wdata : 8'h00, evt[b*8 +: 8]);
                if (hit_en) en_q <= wdata;
            end
        end

        assign sts_flat[b*8 +: 8] = sts_q;
        assign en_flat[b*8 +: 8]  = en_q;
    end

    always_comb begin
        rd_byte = 8'h00;
        for (int k = 0; k < BYTES; k++) begin
            if (int'(addr) == k)         rd_byte = sts_flat[k*8 +: 8];
            if (int'(addr) == BYTES + k) rd_byte = en_flat[k*8 +: 8];
        end
    end

    assign sts0 = sts_flat[7:0];
    assign en0  = en_flat[7:0];

    AST_GPE_EVT_SETS: assert property (@(posedge clk) disable iff (rst)
        (|evt) |=> ((sts_flat & $past(evt)) == $past(evt))); // R3

    AST_GPE_ZERO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr && wdata == 8'h00 && evt == '0 && int'(addr) < BYTES) |=> $stable(sts_flat)); // R3

endmodule

// File: rtl/pm1_bank.sv
module pm1_bank
    import pm_event_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr,
    input  logic [1:0]  off,
    input  logic [7:0]  wdata,
    input  fixed_evt_t  evt,
    output logic [7:0]  rd_byte,
    output logic [15:0] sts,
    output logic [15:0] en,
    output logic        tmr_wake
);

    logic [15:0] sts_q, en_q, en_d, clr;

    always_comb begin
        clr  = '0;
        en_d = en_q;
        if (wr) begin
            case (off)
                2'd0: clr[7:0]   = wdata;
                2'd1: clr[15:8]  = wdata;
                2'd2: en_d[7:0]  = wdata;
                default: en_d[15:8] = wdata;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sts_q <= '0;
            en_q  <= '0;
        end else begin
            sts_q <= ((sts_q & ~clr) | fixed_set_vec(evt)) & PM1_IMPL_MASK;
            en_q  <= en_d;
        end
    end

    always_comb begin
        case (off)
            2'd0: rd_byte = sts_q[7:0];
            2'd1: rd_byte = sts_q[15:8];
            2'd2: rd_byte = en_q[7:0];
            default: rd_byte = en_q[15:8];
        endcase
    end

    assign sts      = sts_q;
    assign en       = en_q;
    assign tmr_wake = en_q[PM1_TMR_BIT] & ~sts_q[PM1_TMR_BIT];

    AST_WAKE_DROPS: assert property (@(posedge clk) disable iff (rst)
        evt.timer |=> !tmr_wake); // R9

    AST_PWR_SETS: assert property (@(posedge clk) disable iff (rst)
        evt.pwr_btn |=> sts_q[PM1_PWR_BIT]); // R10

endmodule

// File: rtl/apm_ctl.sv
module apm_ctl
    import pm_event_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_wr,
    input  logic       cfg_wr,
    input  logic [7:0] wdata,
    output logic       acpi_en,
    output logic [7:0] cmd_q,
    output logic [7:0] cfg_q,
    output logic       smi
);

    always_ff @(posedge clk) begin
        if (rst) begin
            acpi_en <= 1'b0;
            cmd_q   <= '0;
            cfg_q   <= '0;
            smi     <= 1'b0;
        end else begin
            if (cmd_wr) begin
                cmd_q <= wdata;
                if (wdata == CMD_ACPI_ON)       acpi_en <= 1'b1;
                else if (wdata == CMD_ACPI_OFF) acpi_en <= 1'b0;
            end
            if (cfg_wr) cfg_q <= wdata;
            smi <= cmd_wr & cfg_q[CFG_SMI_BIT];
        end
    end

    AST_SMI_CAUSE: assert property (@(posedge clk) disable iff (rst)
        smi |-> $past(cmd_wr)); // R8

    AST_ACPI_ON: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && wdata == CMD_ACPI_ON) |=> acpi_en); // R7

    AST_ACPI_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cmd_wr |=> $stable(acpi_en)); // R7

endmodule

// File: rtl/pm_event_hub.sv
module pm_event_hub
    import pm_event_pkg::*;
#(
    parameter int GPE_BYTES = 2,
    parameter int ADDR_W    = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   bus_wr,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [7:0]             bus_wdata,
    output logic [7:0]             bus_rdata,
    input  logic [GPE_BYTES*8-1:0] gpe_evt,
    input  logic                   evt_timer,
    input  logic                   evt_gbl_lock,
    input  logic                   evt_pwr_btn,
    input  logic                   evt_rtc,
    output logic                   sci,
    output logic                   smi,
    output logic                   tmr_wake
);

    localparam int GPE_WIN   = 2 * GPE_BYTES;
    localparam int GA_W      = (GPE_WIN > 1) ? $clog2(GPE_WIN) : 1;
    localparam int PM1_BASE  = GPE_WIN;
    localparam int CTRL_ADDR = PM1_BASE + 4;
    localparam int CMD_ADDR  = PM1_BASE + 5;
    localparam int CFG_ADDR  = PM1_BASE + 6;

    logic        in_gpe, in_pm1;
    logic [GA_W-1:0] gpe_off;
    logic [1:0]  pm1_off;
    logic [7:0]  gpe_rd, pm1_rd, cmd_q, cfg_q;
    logic [7:0]  gpe_sts0, gpe_en0;
    logic [15:0] pm1_sts, pm1_en;
    logic        acpi_en;
    fixed_evt_t  fevt;

    assign in_gpe  = int'(bus_addr) < GPE_WIN;
    assign in_pm1  = (int'(bus_addr) >= PM1_BASE) && (int'(bus_addr) < PM1_BASE + 4);
    assign gpe_off = GA_W'(bus_addr);
    assign pm1_off = 2'(bus_addr - ADDR_W'(PM1_BASE));

    assign fevt.timer    = evt_timer;
    assign fevt.gbl_lock = evt_gbl_lock;
    assign fevt.pwr_btn  = evt_pwr_btn;
    assign fevt.rtc      = evt_rtc;

    gpe_bank #(.BYTES(GPE_BYTES)) u_gpe (
        .clk     (clk),
        .rst     (rst),
        .wr      (bus_wr && in_gpe),
        .addr    (gpe_off),
        .wdata   (bus_wdata),
        .evt     (gpe_evt),
        .rd_byte (gpe_rd),
        .sts0    (gpe_sts0),
        .en0     (gpe_en0)
    );

    pm1_bank u_pm1 (
        .clk      (clk),
        .rst      (rst),
        .wr       (bus_wr && in_pm1),
        .off      (pm1_off),
        .wdata    (bus_wdata),
        .evt      (fevt),
        .rd_byte  (pm1_rd),
        .sts      (pm1_sts),
        .en       (pm1_en),
        .tmr_wake (tmr_wake)
    );

    apm_ctl u_apm (
        .clk     (clk),
        .rst     (rst),
        .cmd_wr  (bus_wr && int'(bus_addr) == CMD_ADDR),
        .cfg_wr  (bus_wr && int'(bus_addr) == CFG_ADDR),
        .wdata   (bus_wdata),
        .acpi_en (acpi_en),
        .cmd_q   (cmd_q),
        .cfg_q   (cfg_q),
        .smi     (smi)
    );

    assign sci = (|(pm1_sts & pm1_en & PM1_IMPL_MASK)) |
                 (|(gpe_sts0 & gpe_en0 & GPE_SCI_MASK));

    always_comb begin
        if (in_gpe)                          bus_rdata = gpe_rd;
        else if (in_pm1)                     bus_rdata = pm1_rd;
        else if (int'(bus_addr) == CTRL_ADDR) bus_rdata = {7'd0, acpi_en};
        else if (int'(bus_addr) == CMD_ADDR)  bus_rdata = cmd_q;
        else if (int'(bus_addr) == CFG_ADDR)  bus_rdata = cfg_q;
        else                                 bus_rdata = 8'h00;
    end

    AST_SCI_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !sci); // R1

    AST_SCI_PWR_BTN: assert property (@(posedge clk) disable iff (rst)
        (evt_pwr_btn && pm1_en[PM1_PWR_BIT] && !bus_wr) |=> sci); // R4

    AST_SCI_GPE_ENABLE: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && int'(bus_addr) == GPE_BYTES && bus_wdata[1] && gpe_sts0[1])
        |=> sci); // R6

endmodule

// File: tb/pm_event_hub_test.sv
module pm_event_hub_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [15:0] gpe_evt = '0;
    logic        evt_timer = 0, evt_gbl_lock = 0, evt_pwr_btn = 0, evt_rtc = 0;
    logic        sci, smi, tmr_wake;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    pm_event_hub uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .gpe_evt(gpe_evt),
        .evt_timer(evt_timer), .evt_gbl_lock(evt_gbl_lock),
        .evt_pwr_btn(evt_pwr_btn), .evt_rtc(evt_rtc),
        .sci(sci), .smi(smi), .tmr_wake(tmr_wake)
    );

    // behavioural reference state
    logic [15:0] m_gsts, m_gen, m_psts, m_pen;
    logic [7:0]  m_cmd, m_cfg;
    bit          m_acpi, m_smi;

    always @(posedge clk) begin
        if (rst) begin
            m_gsts = 0; m_gen = 0; m_psts = 0; m_pen = 0;
            m_cmd = 0; m_cfg = 0; m_acpi = 0; m_smi = 0;
        end else begin
            m_smi = 0;
            if (bus_wr) begin
                case (bus_addr)
                    0: m_gsts[7:0]  = m_gsts[7:0]  & ~bus_wdata;
                    1: m_gsts[15:8] = m_gsts[15:8] & ~bus_wdata;
                    2: m_gen[7:0]   = bus_wdata;
                    3: m_gen[15:8]  = bus_wdata;
                    4: m_psts[7:0]  = m_psts[7:0]  & ~bus_wdata;
                    5: m_psts[15:8] = m_psts[15:8] & ~bus_wdata;
                    6: m_pen[7:0]   = bus_wdata;
                    7: m_pen[15:8]  = bus_wdata;
                    9: begin
                        m_cmd = bus_wdata;
                        if (bus_wdata == 8'hF1) m_acpi = 1;
                        if (bus_wdata == 8'hF0) m_acpi = 0;
                        m_smi = m_cfg[1];
                    end
                    10: m_cfg = bus_wdata;
                    default: ;
                endcase
            end
            m_gsts = m_gsts | gpe_evt;
            if (evt_timer)    m_psts[0]  = 1;
            if (evt_gbl_lock) m_psts[5]  = 1;
            if (evt_pwr_btn)  m_psts[8]  = 1;
            if (evt_rtc)      m_psts[10] = 1;
        end
    end

    function automatic bit m_sci();
        return ((m_psts & m_pen & 16'h0521) != 0) || ((m_gsts[7:0] & m_gen[7:0] & 8'h06) != 0);
    endfunction

    function automatic logic [7:0] m_read(int a);
        case (a)
            0: return m_gsts[7:0];
            1: return m_gsts[15:8];
            2: return m_gen[7:0];
            3: return m_gen[15:8];
            4: return m_psts[7:0];
            5: return m_psts[15:8];
            6: return m_pen[7:0];
            7: return m_pen[15:8];
            8: return {7'd0, m_acpi};
            9: return m_cmd;
            10: return m_cfg;
            default: return 8'h00;
        endcase
    endfunction

    // per-clock comparison, mid-cycle
    always @(posedge clk) begin
        #5;
        if (!done) begin
            checks++;
            if (sci !== m_sci()) begin
                fails++;
                $display("FAIL R4/R5/R6 sci actual=%0b expected=%0b t=%0t", sci, m_sci(), $time);
            end
            checks++;
            if (smi !== m_smi) begin
                fails++;
                $display("FAIL R8 smi actual=%0b expected=%0b t=%0t", smi, m_smi, $time);
            end
            checks++;
            if (tmr_wake !== (m_pen[0] & ~m_psts[0])) begin
                fails++;
                $display("FAIL R9 tmr_wake actual=%0b expected=%0b t=%0t",
                         tmr_wake, m_pen[0] & ~m_psts[0], $time);
            end
        end
    end

    task automatic cyc(bit w, int a, logic [7:0] d, logic [15:0] ge,
                       bit t, bit g, bit p, bit r);
        @(negedge clk);
        bus_wr = w; bus_addr = 4'(a); bus_wdata = d; gpe_evt = ge;
        evt_timer = t; evt_gbl_lock = g; evt_pwr_btn = p; evt_rtc = r;
    endtask

    task automatic wr(int a, logic [7:0] d);
        cyc(1, a, d, 0, 0, 0, 0, 0);
    endtask

    task automatic idle();
        cyc(0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic rd(int a, string req, logic [7:0] lit, bit use_lit);
        logic [7:0] exp;
        @(negedge clk);
        bus_wr = 0; bus_addr = 4'(a); gpe_evt = 0;
        evt_timer = 0; evt_gbl_lock = 0; evt_pwr_btn = 0; evt_rtc = 0;
        #2;
        exp = use_lit ? lit : m_read(a);
        checks++;
        if (bus_rdata !== exp) begin
            fails++;
            $display("FAIL %s read addr %0d actual=%02h expected=%02h", req, a, bus_rdata, exp);
        end
    endtask

    task automatic chk_bit(string req, bit act, bit exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: reset state
        for (int a = 0; a < 12; a++) rd(a, "R1", 8'h00, 1);
        chk_bit("R1 sci", sci, 0);

        // R5: pending GPE bit1 without enable keeps sci low
        cyc(0, 0, 0, 16'h0002, 0, 0, 0, 0);
        rd(0, "R3", 8'h02, 1);
        chk_bit("R5 sci masked", sci, 0);
        // R6: enable write raises sci the next cycle
        wr(2, 8'h02);
        idle();
        #2 chk_bit("R6 sci after enable", sci, 1);
        // R3: write 0 has no effect, write 1 clears
        wr(0, 8'h00);
        rd(0, "R3", 8'h02, 1);
        wr(0, 8'h02);
        rd(0, "R3", 8'h00, 1);
        chk_bit("R6 sci after clear", sci, 0);

        // R5: other GPE bits do not reach sci, R2 byte layout
        wr(2, 8'hFF);
        wr(3, 8'hFF);
        cyc(0, 0, 0, 16'h0209, 0, 0, 0, 0);
        rd(0, "R2", 8'h09, 1);
        rd(1, "R2", 8'h02, 1);
        rd(2, "R2", 8'hFF, 1);
        rd(3, "R2", 8'hFF, 1);
        chk_bit("R5 other bits", sci, 0);
        // R5: cpu hotplug bit2
        cyc(0, 0, 0, 16'h0004, 0, 0, 0, 0);
        idle();
        #2 chk_bit("R5 bit2", sci, 1);
        // R3: set wins over same-cycle clear
        cyc(1, 0, 8'hFF, 16'h0004, 0, 0, 0, 0);
        rd(0, "R3", 8'h04, 1);
        wr(0, 8'hFF);
        wr(1, 8'hFF);
        rd(0, "R3", 8'h00, 1);
        rd(1, "R3", 8'h00, 1);

        // R10 / R4: fixed events
        cyc(0, 0, 0, 0, 0, 0, 1, 0);
        rd(5, "R10", 8'h01, 1);
        chk_bit("R4 pwr not enabled", sci, 0);
        wr(7, 8'h01);
        idle();
        #2 chk_bit("R4 pwr enabled", sci, 1);
        wr(5, 8'h01);
        cyc(0, 0, 0, 0, 0, 1, 0, 1);
        rd(4, "R10", 8'h20, 1);
        rd(5, "R10", 8'h04, 1);
        chk_bit("R4 gbl/rtc disabled", sci, 0);
        wr(7, 8'h04);
        idle();
        #2 chk_bit("R4 rtc enabled", sci, 1);
        wr(7, 8'h00);
        wr(6, 8'h20);
        idle();
        #2 chk_bit("R4 gbl enabled", sci, 1);
        wr(4, 8'hFF);
        wr(5, 8'hFF);
        rd(4, "R3", 8'h00, 1);
        rd(5, "R3", 8'h00, 1);
        wr(6, 8'hDE);
        wr(7, 8'hFB);
        idle();
        #2 chk_bit("R4 enables alone", sci, 0);

        // R9: timer wake arm
        wr(6, 8'h01);
        wr(7, 8'h00);
        idle();
        #2 chk_bit("R9 armed", tmr_wake, 1);
        cyc(0, 0, 0, 0, 1, 0, 0, 0);
        idle();
        #2 chk_bit("R9 disarmed", tmr_wake, 0);
        chk_bit("R4 timer sci", sci, 1);
        wr(4, 8'h01);
        idle();
        #2 chk_bit("R9 rearmed", tmr_wake, 1);

        // R7: command port
        wr(9, 8'hF1);
        rd(8, "R7", 8'h01, 1);
        wr(9, 8'h55);
        rd(8, "R7", 8'h01, 1);
        rd(9, "R7", 8'h55, 1);
        wr(9, 8'hF0);
        rd(8, "R7", 8'h00, 1);
        wr(8, 8'h01);
        rd(8, "R7", 8'h00, 1);

        // R8: gated smi pulse
        wr(10, 8'h02);
        rd(10, "R8", 8'h02, 1);
        wr(9, 8'h12);
        idle();
        wr(9, 8'hF1);
        wr(9, 8'hF1);
        idle();
        wr(10, 8'hFD);
        wr(9, 8'hF0);
        idle();
        rd(8, "R7", 8'h00, 1);
        for (int a = 0; a < 12; a++) rd(a, "R2", 8'h00, 0);
        repeat (3) idle();

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule